// File: doc/BRIEF.md
# Write-Protected Configuration Register Bank

This block is a bank of 32-bit system configuration words that sits behind an AHB-Lite slave port. Any bus master can read or write it. When reset is asserted, every word takes its value from a static vector of configuration inputs. These inputs stand in for the settings that a nonvolatile programming step would supply.

Static protection inputs decide which bits a bus write may change. Protection works at three levels: a whole word, one 8-bit field of a word, or single bits. A write to a protected bit is dropped without any error indication. A read always returns the current contents of the word. To change the protection or the start-up values, drive new values on the configuration inputs and pulse reset.

Top module: `cfg_reg_bank`

## Requirements
- R1: While `hresetn` is low, every word is loaded from its 32-bit slice of `cfg_init`. Word i uses bits [32i+31:32i]. After reset is released, a read of word i returns that slice.
- R2: `hreadyout` is always 1 and `hresp` is always 0 (OKAY). A read returns the current word value in the data phase that directly follows its address phase.
- R3: A write is allowed only when `cfg_reg_lock`, `cfg_field_lock` and `cfg_bit_lock` are all clear for the word. Such a write replaces all 32 bits with `hwdata` from the data phase. A following read returns the new value.
- R4: When `cfg_reg_lock[i]` is 1, no bus write can change any bit of word i. The write still completes with `hreadyout` = 1 and OKAY.
- R5: Bit 4i+k of `cfg_field_lock` protects field k (bits [8k+7:8k]) of word i. A write changes the unprotected fields and leaves the protected fields unchanged.
- R6: Bit 32i+b of `cfg_bit_lock` protects bit b of word i. The stored result of a write is (old & P) | (hwdata & ~P). P is the OR of the word lock, the field locks and the bit locks.
- R7: A transfer counts only when `hsel` and `hready` are 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). A write with `htrans` IDLE (2'b00) or BUSY (2'b01), with `hsel` low, or with `hready` low changes no word.
- R8: Words sit at byte offsets 0x00, 0x04, … 0x1C (word i at 4i). Any other offset is unmapped, including an offset whose low two bits are not zero. A read of an unmapped offset returns 0 and a write to one changes no word.
- R9: A reset with new configuration input values reloads every word from the new `cfg_init`. After that reset, the new protection values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset; loads the configuration values |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W (8) | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hready | input | 1 | Bus ready; an address phase is taken only when this is high |
| hwdata | input | 32 | Write data, valid in the data phase |
| hrdata | output | 32 | Read data, valid in the data phase |
| hreadyout | output | 1 | Always 1 (no wait states) |
| hresp | output | 1 | Always 0 (OKAY) |
| cfg_init | input | NUM_REGS*32 (256) | Reset value for each word |
| cfg_reg_lock | input | NUM_REGS (8) | Whole-word protection, one bit per word |
| cfg_field_lock | input | NUM_REGS*4 (32) | Protection for each 8-bit field, four bits per word |
| cfg_bit_lock | input | NUM_REGS*32 (256) | Protection for each bit |

## Verification
- **When the design captures an access:** the address phase is taken at a rising edge.
- **When a write takes effect:** at the next rising edge, the end of its data phase. A read issued right after the write therefore sees the new value.
- **When read data is due:** in the cycle right after its address-phase edge, with no wait.
- **How the bench samples:** it drives inputs and samples outputs on falling edges. It reads `hrdata` on the first falling edge after the address-phase edge. Each write is followed by one idle cycle before the next read.
- **What the assertions check:** that a rejected or unmapped write leaves every word unchanged two edges after its address phase.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_CNT = 4;
  localparam int FIELD_W   = WORD_W / FIELD_CNT;

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [FIELD_CNT-1:0] field_t;

  // Widen each field lock bit over the bits of its field.
  function automatic word_t spread_fields(input field_t flock);
    word_t w;
    w = '0;
    for (int k = 0; k < FIELD_CNT; k++) begin
      w[k*FIELD_W +: FIELD_W] = {FIELD_W{flock[k]}};
    end
    return w;
  endfunction

  // A bit is protected if any of the three levels protects it.
  function automatic word_t protect_of(input logic whole, input field_t flock,
                                       input word_t blk);
    return {WORD_W{whole}} | spread_fields(flock) | blk;
  endfunction

  // Protected bits keep the old value; the rest take the write data.
  function automatic word_t merge_write(input word_t old, input word_t wdata,
                                        input word_t prot);
    return (old & prot) | (wdata & ~prot);
  endfunction
endpackage

// File: rtl/cfg_ahb_front.sv
module cfg_ahb_front #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic                hclk,
  input  logic                hresetn,
  input  logic                hsel,
  input  logic [ADDR_W-1:0]   haddr,
  input  logic [1:0]          htrans,
  input  logic                hwrite,
  input  logic                hready,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic                rd_active,
  output logic [IDX_W-1:0]    rd_idx
);
  logic             xfer_now;
  logic             hit_now;
  logic             dp_wr;
  logic             dp_rd;
  logic [IDX_W-1:0] dp_idx;

  assign xfer_now = hsel && hready && (htrans == 2'b10 || htrans == 2'b11);
  assign hit_now  = (haddr[1:0] == 2'b00) &&
                    (int'(haddr[ADDR_W-1:2]) < NUM_REGS);

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      dp_wr  <= 1'b0;
      dp_rd  <= 1'b0;
      dp_idx <= '0;
    end else if (hready) begin
      dp_wr  <= xfer_now && hwrite && hit_now;
      dp_rd  <= xfer_now && !hwrite && hit_now;
      dp_idx <= haddr[ADDR_W-1:2];
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wr_sel[i] = dp_wr && hready && (dp_idx == IDX_W'(i));
  end

  assign rd_active = dp_rd;
  assign rd_idx    = dp_idx;
endmodule

// File: rtl/cfg_lock_mask.sv
module cfg_lock_mask
  import cfg_bank_pkg::*;
(
  input  logic   whole_lock,
  input  field_t field_lock,
  input  word_t  bit_lock,
  output word_t  prot
);
  assign prot = protect_of(whole_lock, field_lock, bit_lock);
endmodule

// File: rtl/cfg_reg_word.sv
module cfg_reg_word
  import cfg_bank_pkg::*;
(
  input  logic  hclk,
  input  logic  hresetn,
  input  word_t init_val,
  input  logic  wr_en,
  input  word_t wdata,
  input  word_t prot,
  output word_t q
);
  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      q <= init_val;
    end else if (wr_en) begin
      q <= merge_write(q, wdata, prot);
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 6
) (
  input  logic                             rd_active,
  input  logic [IDX_W-1:0]                 rd_idx,
  input  logic [NUM_REGS-1:0][WORD_W-1:0]  regs,
  output word_t                            rdata
);
  always_comb begin
    rdata = '0;
    if (rd_active) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (rd_idx == IDX_W'(i)) rdata = regs[i];
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8
) (
  input  logic                          hclk,
  input  logic                          hresetn,
  input  logic                          hsel,
  input  logic [ADDR_W-1:0]             haddr,
  input  logic [1:0]                    htrans,
  input  logic                          hwrite,
  input  logic                          hready,
  input  logic [WORD_W-1:0]             hwdata,
  output logic [WORD_W-1:0]             hrdata,
  output logic                          hreadyout,
  output logic                          hresp,
  input  logic [NUM_REGS*WORD_W-1:0]    cfg_init,
  input  logic [NUM_REGS-1:0]           cfg_reg_lock,
  input  logic [NUM_REGS*FIELD_CNT-1:0] cfg_field_lock,
  input  logic [NUM_REGS*WORD_W-1:0]    cfg_bit_lock
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_REGS-1:0]             wr_sel;
  logic                            rd_active;
  logic [IDX_W-1:0]                rd_idx;
  logic [NUM_REGS-1:0][WORD_W-1:0] reg_flat;
  logic [NUM_REGS-1:0][WORD_W-1:0] prot_flat;

  cfg_ahb_front #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) i_front (
    .hclk      (hclk),
    .hresetn   (hresetn),
    .hsel      (hsel),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hready    (hready),
    .wr_sel    (wr_sel),
    .rd_active (rd_active),
    .rd_idx    (rd_idx)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    cfg_lock_mask i_mask (
      .whole_lock (cfg_reg_lock[i]),
      .field_lock (cfg_field_lock[i*FIELD_CNT +: FIELD_CNT]),
      .bit_lock   (cfg_bit_lock[i*WORD_W +: WORD_W]),
      .prot       (prot_flat[i])
    );

    cfg_reg_word i_word (
      .hclk     (hclk),
      .hresetn  (hresetn),
      .init_val (cfg_init[i*WORD_W +: WORD_W]),
      .wr_en    (wr_sel[i]),
      .wdata    (hwdata),
      .prot     (prot_flat[i]),
      .q        (reg_flat[i])
    );
  end

  cfg_read_mux #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) i_rmux (
    .rd_active (rd_active),
    .rd_idx    (rd_idx),
    .regs      (reg_flat),
    .rdata     (hrdata)
  );

  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;
endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 32
) (
  input logic                            hclk,
  input logic                            hresetn,
  input logic                            hsel,
  input logic [ADDR_W-1:0]               haddr,
  input logic [1:0]                      htrans,
  input logic                            hwrite,
  input logic                            hready,
  input logic [WORD_W-1:0]               hrdata,
  input logic                            hreadyout,
  input logic                            hresp,
  input logic [NUM_REGS*WORD_W-1:0]      cfg_init,
  input logic [NUM_REGS-1:0]             cfg_reg_lock,
  input logic [NUM_REGS-1:0]             wr_sel,
  input logic [NUM_REGS-1:0][WORD_W-1:0] reg_flat,
  input logic [NUM_REGS-1:0][WORD_W-1:0] prot_flat
);
  logic active_now;
  logic wr_req;
  logic rd_req;
  logic mapped;

  assign active_now = hsel && hready && (htrans == 2'b10 || htrans == 2'b11);
  assign wr_req     = active_now && hwrite;
  assign rd_req     = active_now && !hwrite;
  assign mapped     = (haddr[1:0] == 2'b00) && (int'(haddr[ADDR_W-1:2]) < NUM_REGS);

  AST_RESET_LOADS_INIT: assert property (@(posedge hclk) disable iff (!hresetn)
    $rose(hresetn) |-> (reg_flat == cfg_init)); // R1

  AST_READYOUT_HIGH: assert property (@(posedge hclk) disable iff (!hresetn)
    hreadyout); // R2

  AST_RESP_OKAY: assert property (@(posedge hclk) disable iff (!hresetn)
    !hresp); // R2

  AST_WR_SEL_ONEHOT: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0(wr_sel)); // R3

  AST_REJECTED_WRITE_NO_CHANGE: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && !wr_req) |=> ##1 $stable(reg_flat)); // R7

  AST_UNMAPPED_WRITE_NO_CHANGE: assert property (@(posedge hclk) disable iff (!hresetn)
    (wr_req && !mapped) |=> ##1 $stable(reg_flat)); // R8

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge hclk) disable iff (!hresetn)
    (rd_req && !mapped) |=> (hrdata == '0)); // R8

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word_chk
    AST_READ_RETURNS_WORD: assert property (@(posedge hclk) disable iff (!hresetn)
      (rd_req && haddr == ADDR_W'(4*i)) |=> (hrdata == reg_flat[i])); // R2

    AST_LOCKED_WORD_STABLE: assert property (@(posedge hclk) disable iff (!hresetn)
      cfg_reg_lock[i] |=> $stable(reg_flat[i])); // R4

    AST_PROTECTED_BITS_HOLD: assert property (@(posedge hclk) disable iff (!hresetn)
      ((reg_flat[i] & prot_flat[i]) == ($past(reg_flat[i]) & prot_flat[i]))); // R6
  end
endmodule

bind cfg_reg_bank cfg_reg_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .ADDR_W   (ADDR_W),
  .WORD_W   (cfg_bank_pkg::WORD_W)
) i_chk (
  .hclk         (hclk),
  .hresetn      (hresetn),
  .hsel         (hsel),
  .haddr        (haddr),
  .htrans       (htrans),
  .hwrite       (hwrite),
  .hready       (hready),
  .hrdata       (hrdata),
  .hreadyout    (hreadyout),
  .hresp        (hresp),
  .cfg_init     (cfg_init),
  .cfg_reg_lock (cfg_reg_lock),
  .wr_sel       (wr_sel),
  .reg_flat     (reg_flat),
  .prot_flat    (prot_flat)
);

// File: tb/test_cfg_reg_bank.sv
`timescale 1ns/1ps
module test_cfg_reg_bank;
  localparam int NREG = 8;
  localparam int AW   = 8;
  localparam int NVEC = 10;

  logic              clk = 1'b0;
  logic              hresetn;
  logic              hsel;
  logic [AW-1:0]     haddr;
  logic [1:0]        htrans;
  logic              hwrite;
  logic              hready;
  logic [31:0]       hwdata;
  logic [31:0]       hrdata;
  logic              hreadyout;
  logic              hresp;
  logic [NREG*32-1:0] cfg_init;
  logic [NREG-1:0]    cfg_reg_lock;
  logic [NREG*4-1:0]  cfg_field_lock;
  logic [NREG*32-1:0] cfg_bit_lock;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  logic [31:0] shadow [NREG];

  always #2 clk = ~clk;

  cfg_reg_bank #(.NUM_REGS(NREG), .ADDR_W(AW)) i_cfg_reg_bank (
    .hclk (clk), .hresetn (hresetn), .hsel (hsel), .haddr (haddr),
    .htrans (htrans), .hwrite (hwrite), .hready (hready), .hwdata (hwdata),
    .hrdata (hrdata), .hreadyout (hreadyout), .hresp (hresp),
    .cfg_init (cfg_init), .cfg_reg_lock (cfg_reg_lock),
    .cfg_field_lock (cfg_field_lock), .cfg_bit_lock (cfg_bit_lock)
  );

  // {byte offset, write data, expected read-back}; configuration A is active.
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h00, 32'hDEADBEEF, 32'hDEADBEEF},  // R3 open word
    {8'h04, 32'h00000000, 32'h00000000},  // R3 open word
    {8'h08, 32'hFFFFFFFF, 32'h12121212},  // R4 whole word locked
    {8'h0C, 32'hAABBCCDD, 32'h13BB13DD},  // R5 fields 1 and 3 locked
    {8'h10, 32'hCAFEF00D, 32'hCAFE1414},  // R6 low half bit-locked
    {8'h14, 32'h7FFFFFFE, 32'h7FFFFFFF},  // R6 bits 31 and 0 locked
    {8'h18, 32'hFFFFFFFF, 32'h7FFFFF16},  // R5 field 0 plus bit 31
    {8'h1C, 32'h12345678, 32'h12345678},  // R3 open word
    {8'h00, 32'h0F0F0F0F, 32'h0F0F0F0F},  // R3 overwrite again
    {8'h0C, 32'h00000000, 32'h13001300}   // R5 clear open fields
  };

  function automatic string vec_req(input int k);
    case (k)
      2:       return "R4";
      3, 6, 9: return "R5";
      4, 5:    return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic load_config(input bit variant_b);
    cfg_reg_lock   = '0;
    cfg_field_lock = '0;
    cfg_bit_lock   = '0;
    for (int i = 0; i < NREG; i++) begin
      cfg_init[i*32 +: 32] = {4{(variant_b ? 8'h40 : 8'h10) + 8'(i)}};
      shadow[i]            = cfg_init[i*32 +: 32];
    end
    if (!variant_b) begin
      cfg_reg_lock[2]          = 1'b1;
      cfg_field_lock[3*4 +: 4] = 4'b1010;
      cfg_field_lock[6*4 +: 4] = 4'b0001;
      cfg_bit_lock[4*32 +: 32] = 32'h0000FFFF;
      cfg_bit_lock[5*32 +: 32] = 32'h80000001;
      cfg_bit_lock[6*32 +: 32] = 32'h80000000;
    end else begin
      cfg_reg_lock[5] = 1'b1;
    end
  endtask

  task automatic idle_bus();
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hready = 1'b1; haddr = '0;
  endtask

  // Address phase, data phase, then one idle cycle. Called at a falling edge.
  task automatic bus_cycle(input logic sel, input logic [1:0] trans, input logic wr,
                           input logic rdy, input logic [7:0] addr, input logic [31:0] data);
    hsel = sel; htrans = trans; hwrite = wr; hready = rdy; haddr = addr;
    @(negedge clk);
    idle_bus();
    hwdata = data;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] addr, input logic [31:0] data);
    bus_cycle(1'b1, 2'b10, 1'b1, 1'b1, addr, data);
  endtask

  task automatic bus_read(input logic [7:0] addr, output logic [31:0] rd,
                          output logic rdy, output logic rsp);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; hready = 1'b1; haddr = addr;
    @(negedge clk);
    idle_bus();
    rd = hrdata; rdy = hreadyout; rsp = hresp;
  endtask

  task automatic check_all(input string req);
    logic [31:0] rd;
    logic rdy, rsp;
    for (int i = 0; i < NREG; i++) begin
      bus_read(8'(4*i), rd, rdy, rsp);
      check(req, rd, shadow[i]);
    end
  endtask

  task automatic apply_reset();
    hresetn = 1'b0;
    repeat (3) @(negedge clk);
    hresetn = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic rdy, rsp;
    hwdata = '0;
    idle_bus();
    load_config(1'b0);
    apply_reset();

    // R1 reset values
    check_all("R1");

    // R2 zero wait state, OKAY, read of current value
    bus_read(8'h04, rd, rdy, rsp);
    check("R2", 32'(rdy), 32'd1);
    check("R2", 32'(rsp), 32'd0);
    check("R2", rd, shadow[1]);

    // Table walk: write, then read back
    for (int k = 0; k < NVEC; k++) begin
      bus_write(VEC[k][71:64], VEC[k][63:32]);
      bus_read(VEC[k][71:64], rd, rdy, rsp);
      check(vec_req(k), rd, VEC[k][31:0]);
      check("R2", 32'({rdy, rsp}), 32'b10);
      shadow[VEC[k][71:66]] = VEC[k][31:0];
    end
    check_all("R6");

    // R7 qualifiers
    bus_cycle(1'b0, 2'b10, 1'b1, 1'b1, 8'h00, 32'h11111111);
    bus_cycle(1'b1, 2'b00, 1'b1, 1'b1, 8'h00, 32'h22222222);
    bus_cycle(1'b1, 2'b01, 1'b1, 1'b1, 8'h00, 32'h33333333);
    bus_cycle(1'b1, 2'b10, 1'b1, 1'b0, 8'h00, 32'h44444444);
    bus_read(8'h00, rd, rdy, rsp);
    check("R7", rd, shadow[0]);
    bus_cycle(1'b1, 2'b11, 1'b1, 1'b1, 8'h04, 32'h5A5A5A5A);
    shadow[1] = 32'h5A5A5A5A;
    bus_read(8'h04, rd, rdy, rsp);
    check("R7", rd, shadow[1]);

    // R8 unmapped and misaligned offsets
    bus_write(8'h20, 32'hFFFFFFFF);
    bus_write(8'hFC, 32'hFFFFFFFF);
    bus_write(8'h01, 32'hFFFFFFFF);
    check_all("R8");
    bus_read(8'h20, rd, rdy, rsp);
    check("R8", rd, 32'h0);
    bus_read(8'h02, rd, rdy, rsp);
    check("R8", rd, 32'h0);
    check("R8", 32'({rdy, rsp}), 32'b10);

    // R9 reconfiguration through reset
    load_config(1'b1);
    apply_reset();
    check_all("R9");
    bus_write(8'h08, 32'hFFFFFFFF);
    shadow[2] = 32'hFFFFFFFF;
    bus_read(8'h08, rd, rdy, rsp);
    check("R9", rd, shadow[2]);
    bus_write(8'h14, 32'h00000000);
    bus_read(8'h14, rd, rdy, rsp);
    check("R9", rd, 32'h45454545);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule